// File: doc/BRIEF.md
# Interrupt Return Frame Popper

This block carries out the stack-reading half of a return from an interrupt handler. A single-cycle `start` pulse captures the current execution mode (64-bit or compatibility), the current privilege level, the current stack pointer and stack selector, and a flag from the descriptor stage. That flag tells the block whether the return lands in a 64-bit code segment. The block then reads 8-byte words from the stack over a request/acknowledge read port. The first three words hold the instruction pointer, the code selector and the flags word.

The popped code selector gives the target privilege level in its two low bits. From it the block decides whether the stack pointer and stack selector must also be read. In 64-bit mode they always are. In compatibility mode they are read only when the privilege level changes. When they are not read, the restored stack pointer simply moves past the three words consumed.

A popped stack selector whose index and table bits are all zero is a null selector. Such a selector does not request a descriptor load. It is legal only when the return goes to 64-bit code at a privilege level other than 3. In every other case it raises a fault, and the restored state is left as it was.

Top module: `iret_frame_pop`

## Requirements
- R1: After reset, `busy`, `done`, `fault`, `rd_req` and `ss_load_req` are 0, and every restored-value output is 0.
- R2: Reads go out in slot order: instruction pointer, code selector, flags, stack pointer, stack selector. Slot n is read at address captured_rsp + 8*n. A read is accepted in a cycle where `rd_req` and `rd_ack` are both 1. While a request is not yet accepted, `rd_req` stays high and `rd_addr` does not change.
- R3: When the captured mode is 64-bit (`cur_is64`=1), all five slots are read, whatever the privilege levels.
- R4: When the captured mode is compatibility (`cur_is64`=0), five slots are read if the popped code selector bits [1:0] differ from `cur_cpl`. Otherwise exactly three slots are read.
- R5: After a three-slot return, `out_rsp` equals captured_rsp + 24, `out_ss` equals the captured `cur_ss`, and `ss_load_req` is 0.
- R6: After a five-slot return with a non-null popped stack selector (bits [15:2] not all zero), `out_rsp` and `out_ss` take the popped values (`out_ss` = popped word bits [15:0]) and `ss_load_req` is 1.
- R7: A popped null stack selector is accepted without a fault when `tgt_code64`=1 and the code selector bits [1:0] are not 3. In that case `out_ss` is the popped selector with its low two bits kept, and `ss_load_req` is 0.
- R8: A popped null stack selector with `tgt_code64`=0, or with code selector bits [1:0] equal to 3, sets `fault` for the single cycle in which `done` is high. Every restored-value output and `ss_load_req` then keeps the value it had before.
- R9: `done` is high for exactly one cycle. That cycle is the one right after the final read is accepted, and the outputs hold the new values in that cycle.
- R10: `start` is ignored while a return is in progress and during the `done` cycle. Changes on the mode, privilege, stack and target inputs after the accepting `start` have no effect on that return.
- R11: On a return without a fault, `out_rip`, `out_cs` (bits [15:0]) and `out_rflags` equal the words popped from slots 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a return; honoured only when idle |
| cur_is64 | input | 1 | Current mode: 1 = 64-bit, 0 = compatibility |
| cur_cpl | input | 2 | Current privilege level |
| tgt_code64 | input | 1 | Return target code segment is 64-bit |
| cur_rsp | input | 64 | Current stack pointer (frame base) |
| cur_ss | input | 16 | Current stack selector |
| rd_req | output | 1 | Stack read request |
| rd_addr | output | ADDR_W | Stack read byte address |
| rd_ack | input | 1 | Read accepted; `rd_data` valid this cycle |
| rd_data | input | 64 | Read data |
| busy | output | 1 | Frame reads in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Null stack selector rejected (with `done`) |
| out_rip | output | 64 | Restored instruction pointer |
| out_cs | output | 16 | Restored code selector |
| out_rflags | output | 64 | Restored flags word |
| out_rsp | output | 64 | Restored stack pointer |
| out_ss | output | 16 | Restored stack selector |
| ss_load_req | output | 1 | Stack descriptor load required |

## Verification
The embedded properties assume three things about the memory side. First, `rd_ack` is raised only while `rd_req` is high. Second, `rd_data` is valid in the same cycle as the acknowledge. Third, `start` arrives as a pulse. The assumptions also take `tgt_code64` as stable meaningful descriptor information for the return being handled. The bench memory model drives the acknowledge only after it has seen a request at the falling edge. It varies the wait before each acknowledge between zero and two cycles, so back-to-back and stalled reads both occur. The bench changes the mode and stack inputs only after the accepting pulse, and it sends `start` while busy and during the completion cycle to show that these pulses are dropped.

// File: rtl/iret_pkg.sv
package iret_pkg;

    localparam int WORD_W        = 64;
    localparam int SEL_W         = 16;
    localparam int SLOT_BYTES    = 8;
    localparam int SLOT_SHIFT    = $clog2(SLOT_BYTES);
    localparam int NUM_SLOTS     = 5;
    localparam int SHORT_SLOTS   = 3;
    localparam int SHORT_ADVANCE = SHORT_SLOTS * SLOT_BYTES;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_DONE
    } seq_state_e;

    // Slot order is behaviour: it fixes the stack offsets.
    typedef enum logic [2:0] {
        SLOT_RIP = 3'd0,
        SLOT_CS  = 3'd1,
        SLOT_RFL = 3'd2,
        SLOT_RSP = 3'd3,
        SLOT_SS  = 3'd4
    } slot_e;

    typedef struct packed {
        logic              is64;
        logic [1:0]        cpl;
        logic              tgt64;
        logic [WORD_W-1:0] rsp;
        logic [SEL_W-1:0]  ss;
    } ctx_t;

    typedef struct packed {
        logic [WORD_W-1:0] rip;
        logic [SEL_W-1:0]  cs;
        logic [WORD_W-1:0] rfl;
        logic [WORD_W-1:0] rsp;
        logic [SEL_W-1:0]  ss;
    } frame_t;

    function automatic int slot_width(int idx);
        return (idx == int'(SLOT_CS) || idx == int'(SLOT_SS)) ? SEL_W : WORD_W;
    endfunction

    function automatic logic sel_is_null(logic [SEL_W-1:0] sel);
        return sel[SEL_W-1:2] == '0;
    endfunction

    function automatic logic [1:0] sel_rpl(logic [SEL_W-1:0] sel);
        return sel[1:0];
    endfunction

    function automatic logic null_ss_allowed(logic tgt64, logic [1:0] tcpl);
        return tgt64 && (tcpl != 2'd3);
    endfunction

    function automatic logic needs_full_pop(logic is64, logic [1:0] cur, logic [1:0] tcpl);
        return is64 || (tcpl != cur);
    endfunction

endpackage

// File: rtl/iret_seq.sv
module iret_seq
    import iret_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic              rd_ack,
    input  logic              full_pop,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output slot_e             slot,
    output logic              accept,
    output logic              last,
    output logic              launch,
    output logic              busy,
    output logic              done
);

    seq_state_e        st_q;
    slot_e             slot_q;
    logic [ADDR_W-1:0] base_q;

    assign launch = start && (st_q == ST_IDLE);
    assign accept = (st_q == ST_READ) && rd_ack;
    assign last   = accept && ((slot_q == SLOT_SS) ||
                               ((slot_q == SLOT_RFL) && !full_pop));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            slot_q <= SLOT_RIP;
            base_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        base_q <= base;
                        slot_q <= SLOT_RIP;
                        st_q   <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (last) begin
                        st_q <= ST_DONE;
                    end else if (accept) begin
                        slot_q <= slot_e'(slot_q + 3'd1);
                    end
                end
                ST_DONE: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign rd_req  = (st_q == ST_READ);
    assign rd_addr = base_q + (ADDR_W'(slot_q) << SLOT_SHIFT);
    assign slot    = slot_q;
    assign busy    = (st_q == ST_READ);
    assign done    = (st_q == ST_DONE);

    // accepted-read counter for the frame-length check
    logic [2:0] acc_cnt_q;
    always_ff @(posedge clk) begin
        if (rst || launch) acc_cnt_q <= '0;
        else if (accept)   acc_cnt_q <= acc_cnt_q + 3'd1;
    end

    p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_follows_read_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(rd_req && rd_ack));

    p_frame_len_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (acc_cnt_q == 3'(SHORT_SLOTS) || acc_cnt_q == 3'(NUM_SLOTS)));

endmodule

// File: rtl/iret_capture.sv
module iret_capture
    import iret_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  slot_e             slot,
    input  logic [WORD_W-1:0] rd_data,
    output frame_t            frame_nx
);

    // One register per slot, sized to what that slot carries.
    // frame_nx overlays the word being accepted this cycle.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        localparam int W = slot_width(g);
        logic [W-1:0] q;
        logic [W-1:0] nx;
        logic         hit;

        assign hit = accept && (slot == slot_e'(g));

        always_ff @(posedge clk) begin
            if (rst)      q <= '0;
            else if (hit) q <= rd_data[W-1:0];
        end

        assign nx = hit ? rd_data[W-1:0] : q;
    end

    assign frame_nx.rip = g_slot[0].nx;
    assign frame_nx.cs  = g_slot[1].nx;
    assign frame_nx.rfl = g_slot[2].nx;
    assign frame_nx.rsp = g_slot[3].nx;
    assign frame_nx.ss  = g_slot[4].nx;

endmodule

// File: rtl/iret_ss_policy.sv
module iret_ss_policy
    import iret_pkg::*;
(
    input  logic             is64,
    input  logic [1:0]       cur_cpl,
    input  logic             tgt64,
    input  logic [SEL_W-1:0] cs_sel,
    input  logic [SEL_W-1:0] ss_sel,
    output logic             full_pop,
    output logic             ss_fault,
    output logic             ss_load
);

    logic [1:0] tcpl;
    logic       ss_null;

    always_comb begin
        tcpl     = sel_rpl(cs_sel);
        full_pop = needs_full_pop(is64, cur_cpl, tcpl);
        ss_null  = sel_is_null(ss_sel);
        ss_fault = full_pop && ss_null && !null_ss_allowed(tgt64, tcpl);
        ss_load  = full_pop && !ss_null;
    end

endmodule

// File: rtl/iret_frame_pop.sv
module iret_frame_pop
    import iret_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cur_is64,
    input  logic [1:0]        cur_cpl,
    input  logic              tgt_code64,
    input  logic [WORD_W-1:0] cur_rsp,
    input  logic [SEL_W-1:0]  cur_ss,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [WORD_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [WORD_W-1:0] out_rip,
    output logic [SEL_W-1:0]  out_cs,
    output logic [WORD_W-1:0] out_rflags,
    output logic [WORD_W-1:0] out_rsp,
    output logic [SEL_W-1:0]  out_ss,
    output logic              ss_load_req
);

    ctx_t   ctx_q;
    frame_t frame_nx;
    slot_e  slot;
    logic   accept, last, launch;
    logic   full_pop, ss_fault, ss_load;

    iret_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .base     (cur_rsp[ADDR_W-1:0]),
        .rd_ack   (rd_ack),
        .full_pop (full_pop),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .slot     (slot),
        .accept   (accept),
        .last     (last),
        .launch   (launch),
        .busy     (busy),
        .done     (done)
    );

    iret_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .slot     (slot),
        .rd_data  (rd_data),
        .frame_nx (frame_nx)
    );

    iret_ss_policy u_pol (
        .is64     (ctx_q.is64),
        .cur_cpl  (ctx_q.cpl),
        .tgt64    (ctx_q.tgt64),
        .cs_sel   (frame_nx.cs),
        .ss_sel   (frame_nx.ss),
        .full_pop (full_pop),
        .ss_fault (ss_fault),
        .ss_load  (ss_load)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '0;
        end else if (launch) begin
            ctx_q.is64  <= cur_is64;
            ctx_q.cpl   <= cur_cpl;
            ctx_q.tgt64 <= tgt_code64;
            ctx_q.rsp   <= cur_rsp;
            ctx_q.ss    <= cur_ss;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault       <= 1'b0;
            out_rip     <= '0;
            out_cs      <= '0;
            out_rflags  <= '0;
            out_rsp     <= '0;
            out_ss      <= '0;
            ss_load_req <= 1'b0;
        end else begin
            fault <= 1'b0;
            if (last) begin
                if (full_pop && ss_fault) begin
                    fault <= 1'b1;
                end else begin
                    out_rip    <= frame_nx.rip;
                    out_cs     <= frame_nx.cs;
                    out_rflags <= frame_nx.rfl;
                    if (full_pop) begin
                        out_rsp     <= frame_nx.rsp;
                        out_ss      <= frame_nx.ss;
                        ss_load_req <= ss_load;
                    end else begin
                        out_rsp     <= ctx_q.rsp + WORD_W'(SHORT_ADVANCE);
                        out_ss      <= ctx_q.ss;
                        ss_load_req <= 1'b0;
                    end
                end
            end
        end
    end

    p_fault_with_done_r8: assert property (@(posedge clk) disable iff (rst)
        fault |-> done);

    p_hold_on_fault_r8: assert property (@(posedge clk) disable iff (rst)
        fault |-> ($stable(out_rip) && $stable(out_rsp) &&
                   $stable(out_ss) && $stable(ss_load_req)));

    p_load_nonnull_r6: assert property (@(posedge clk) disable iff (rst)
        (done && ss_load_req) |-> (out_ss[SEL_W-1:2] != '0));

    p_ctx_hold_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ctx_q));

endmodule

// File: tb/iret_frame_pop_tb.sv
module iret_frame_pop_tb;
    import iret_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        cur_is64 = 1'b0;
    logic [1:0]  cur_cpl = '0;
    logic        tgt_code64 = 1'b0;
    logic [63:0] cur_rsp = '0;
    logic [15:0] cur_ss = '0;
    logic        rd_req;
    logic [63:0] rd_addr;
    logic        rd_ack = 1'b0;
    logic [63:0] rd_data = '0;
    logic        busy, done, fault, ss_load_req;
    logic [63:0] out_rip, out_rflags, out_rsp;
    logic [15:0] out_cs, out_ss;

    always #2 clk = ~clk;

    iret_frame_pop u_dut (
        .clk(clk), .rst(rst), .start(start), .cur_is64(cur_is64),
        .cur_cpl(cur_cpl), .tgt_code64(tgt_code64), .cur_rsp(cur_rsp),
        .cur_ss(cur_ss), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
        .rd_data(rd_data), .busy(busy), .done(done), .fault(fault),
        .out_rip(out_rip), .out_cs(out_cs), .out_rflags(out_rflags),
        .out_rsp(out_rsp), .out_ss(out_ss), .ss_load_req(ss_load_req)
    );

    typedef struct {
        bit          flt;
        logic [63:0] rip;
        logic [15:0] cs;
        logic [63:0] rfl;
        logic [63:0] rsp;
        logic [15:0] ss;
        bit          load;
        string       req;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          fails = 0;
    bit          finished = 0;
    logic [63:0] fr [5];
    logic [63:0] fbase = '0;
    int          reads = 0;
    int          dly = 0;
    int          trn = 0;
    exp_t        lg;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory model: acknowledge after 0..2 idle cycles; checks R2 address order
    always @(negedge clk) begin
        if (rst) begin
            rd_ack = 1'b0;
        end else if (rd_req) begin
            if (dly == 0) begin
                rd_ack = 1'b1;
                chk("R2", "read address", rd_addr, fbase + 64'(8 * reads));
                rd_data = fr[reads < 5 ? reads : 0];
                reads++;
                dly = (reads + trn) % 3;
            end else begin
                rd_ack = 1'b0;
                dly--;
            end
        end else begin
            rd_ack = 1'b0;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb.size() == 0) begin
                chk("R9", "unexpected done", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(e.req, "fault", 64'(fault), 64'(e.flt));
                chk("R11", "out_rip", out_rip, e.rip);
                chk("R11", "out_cs", 64'(out_cs), 64'(e.cs));
                chk("R11", "out_rflags", out_rflags, e.rfl);
                chk(e.req, "out_rsp", out_rsp, e.rsp);
                chk(e.req, "out_ss", 64'(out_ss), 64'(e.ss));
                chk(e.req, "ss_load_req", 64'(ss_load_req), 64'(e.load));
            end
        end
    end

    // mode: 0 plain, 1 stray start mid-flight, 2 start during done cycle
    task automatic run(bit is64, logic [1:0] cpl, bit tgt64, logic [63:0] crsp,
                       logic [15:0] css, logic [63:0] rip, logic [15:0] cs,
                       logic [63:0] rfl, logic [63:0] prsp, logic [15:0] pss,
                       int mode, string req);
        exp_t e;
        bit   full;
        int   nreads;
        fr[0] = rip; fr[1] = {48'hdead_beef_0000, cs}; fr[2] = rfl;
        fr[3] = prsp; fr[4] = {48'h0123_4567_89ab, pss};
        fbase = crsp; reads = 0; trn++;
        full = is64 || (cs[1:0] != cpl);
        nreads = full ? 5 : 3;
        e.req = req;
        e.flt = 0;
        if (full && pss[15:2] == 0 && !(tgt64 && cs[1:0] != 2'd3)) begin
            e = lg; e.flt = 1; e.req = req;
        end else begin
            e.rip = rip; e.cs = cs; e.rfl = rfl;
            if (full) begin
                e.rsp = prsp; e.ss = pss; e.load = (pss[15:2] != 0);
            end else begin
                e.rsp = crsp + 64'd24; e.ss = css; e.load = 0;
            end
            lg = e;
        end
        sb.push_back(e);
        cur_is64 = is64; cur_cpl = cpl; tgt_code64 = tgt64;
        cur_rsp = crsp; cur_ss = css;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (mode == 1) begin
            @(negedge clk);
            cur_rsp = ~crsp; cur_is64 = !is64; cur_cpl = ~cpl;
            tgt_code64 = !tgt64; cur_ss = ~css;
            start = 1'b1;  // R10: ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        chk(is64 ? "R3" : "R4", "read count", 64'(reads), 64'(nreads));
        if (mode == 2) start = 1'b1;  // R10: ignored in done cycle
        @(negedge clk);
        start = 1'b0;
        chk("R9", "done after pulse", 64'(done), 64'd0);
        chk("R10", "busy after done", 64'(busy), 64'd0);
        @(negedge clk);
        chk("R10", "no request after ignored start", 64'(rd_req), 64'd0);
    endtask

    initial begin
        lg = '{flt: 0, rip: '0, cs: '0, rfl: '0, rsp: '0, ss: '0, load: 0, req: ""};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1", "busy", 64'(busy), 64'd0);
        chk("R1", "done", 64'(done), 64'd0);
        chk("R1", "fault", 64'(fault), 64'd0);
        chk("R1", "rd_req", 64'(rd_req), 64'd0);
        chk("R1", "ss_load_req", 64'(ss_load_req), 64'd0);
        chk("R1", "out_rsp", out_rsp, 64'd0);
        chk("R1", "out_rip", out_rip, 64'd0);
        @(negedge clk);
        // R3/R6: 64-bit mode, same level 0, non-null SS
        run(1, 2'd0, 1, 64'h0000_7fff_0000_1000, 16'h0018, 64'hffff_8000_0000_1234,
            16'h0010, 64'h0000_0246, 64'h0000_7fff_0000_2000, 16'h002b, 0, "R6");
        // R4/R5: compatibility, no level change
        run(0, 2'd3, 0, 64'h0000_0000_00ff_f000, 16'h0023, 64'h0000_0000_0040_0000,
            16'h001b, 64'h0000_0202, 64'h0, 16'h0, 0, "R5");
        // R4/R6: compatibility, level change
        run(0, 2'd0, 0, 64'h0000_0000_0010_0080, 16'h0010, 64'h0000_0000_0800_0010,
            16'h0023, 64'h0000_0293, 64'h0000_0000_0bff_fff0, 16'h002b, 0, "R6");
        // R7: null SS, 64-bit target, level 0
        run(1, 2'd0, 1, 64'h0000_0000_0020_0000, 16'h0018, 64'hffff_8000_0000_5678,
            16'h0010, 64'h0000_0086, 64'h0000_0000_0030_0000, 16'h0000, 0, "R7");
        // R7: null SS with RPL 2, target level 2
        run(1, 2'd0, 1, 64'h0000_0000_0020_4000, 16'h0018, 64'h0000_0000_0050_0000,
            16'h004a, 64'h0000_0046, 64'h0000_0000_0060_0000, 16'h0002, 1, "R7");
        // R8: null SS at target level 3
        run(1, 2'd0, 1, 64'h0000_0000_0030_0000, 16'h0018, 64'h1111,
            16'h0033, 64'h2222, 64'h3333, 16'h0003, 0, "R8");
        // R8: null SS, compatibility target
        run(0, 2'd0, 0, 64'h0000_0000_0031_0000, 16'h0018, 64'h4444,
            16'h0023, 64'h5555, 64'h6666, 16'h0000, 2, "R8");
        // R10 + R5: stray starts around a short frame
        run(0, 2'd1, 0, 64'h0000_0000_0040_0010, 16'h0029, 64'h0000_0000_0070_0000,
            16'h0029, 64'h0000_0202, 64'h0, 16'h0, 1, "R5");
        // R3: 64-bit mode, level 3 to 3, non-null SS still popped
        run(1, 2'd3, 1, 64'h0000_7fff_ffff_e000, 16'h002b, 64'h0000_0000_0040_1000,
            16'h0033, 64'h0000_0202, 64'h0000_7fff_ffff_f000, 16'h002b, 2, "R3");
        chk("R9", "scoreboard drained", 64'(sb.size()), 64'd0);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule